// File: doc/BRIEF.md
# Parallel ADC Host Sequencer

This block is the host-side sequencer for a parallel analog-to-digital converter that has two input banks and can digitise one to four channels per start. A command gives the bank, the channel count and an optional power-down request. The sequencer turns the command into a 4-bit mode word. It writes the word to the converter with a chip-select and write-strobe cycle. It then fires the convert strobe and waits for the converter's active-low done interrupt. After that it runs one read cycle for each programmed channel. Each 12-bit result leaves the block on a valid/data stream with a channel tag.

The sequencer keeps a copy of the last mode word it wrote. A command that asks for the same word skips the write cycle and starts converting straight away. Every pulse width and gap is a parameter counted in clock cycles. The interrupt passes through a parameterised synchroniser. If the interrupt does not arrive within a set number of cycles, a watchdog aborts the command and raises an error pulse.

Top module: `adc_seq_host`

## Requirements
- R1: The mode word on `adc_mode_o` (bit i drives converter pin i) is {pdown, bank, cnt_m1[1], cnt_m1[0]}. Bank A is 0 and bank B is 1. The field `cnt_m1` is the channel count minus one, so counts 1, 2, 3 and 4 give bits [1:0] = 00, 01, 10 and 11. A power-down word is 4'b1000.
- R2: A write cycle holds `adc_cs_n` low and `adc_mode_oe` high throughout. `adc_wr_n` falls after T_SU cycles of chip-select and stays low for T_WR cycles. The word is then held for T_HOLD cycles before chip-select rises. The word does not change while it is driven.
- R3: A write cycle happens for the first command after reset and for any command whose mode word differs from the last one written. Otherwise the write cycle is skipped.
- R4: Each conversion command produces exactly one `adc_cnv_n` low pulse of T_CNV cycles. A new pulse never starts while the previous conversion is still awaiting its interrupt.
- R5: `adc_rd_n` never falls between the start of a convert pulse and the interrupt being seen low.
- R6: After the interrupt, the block performs exactly cnt_m1+1 read pulses under chip-select, each T_RD cycles wide. Results carry channel tags 0, 1, 2 and 3 in order.
- R7: Read data is captured in the last low cycle of `adc_rd_n`. `res_valid` is high for exactly one cycle, the cycle in which `adc_rd_n` has just risen.
- R8: The interrupt counts if its synchronised level (SYNC_STAGES flops) is low in one of the first TIMEOUT cycles after the convert strobe rises. A low level in the last of those cycles still counts. Otherwise `err_timeout` pulses for one cycle, no read is issued, and the block is ready again.
- R9: `cmd_ready` is low from the cycle after acceptance until the last result has been delivered. It is never high together with `res_valid`.
- R10: A power-down command writes the power-down word if it differs from the cached word. It issues no convert pulse and returns to ready.
- R11: In reset, all four strobes are high, `adc_mode_oe`, `res_valid` and `err_timeout` are low, and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_bank | input | 1 | 0 selects bank A, 1 selects bank B |
| cmd_cnt_m1 | input | 2 | Channel count minus one |
| cmd_pdown | input | 1 | Request converter power-down |
| res_valid | output | 1 | Result strobe |
| res_data | output | DATA_W | Conversion result |
| res_chan | output | 2 | Channel index of the result |
| err_timeout | output | 1 | One-cycle pulse on interrupt timeout |
| adc_cs_n | output | 1 | Converter chip-select, active low |
| adc_wr_n | output | 1 | Converter write strobe, active low |
| adc_rd_n | output | 1 | Converter read strobe, active low |
| adc_cnv_n | output | 1 | Converter convert strobe, active low |
| adc_mode_o | output | 4 | Mode word toward the converter pins |
| adc_mode_oe | output | 1 | Drive enable for the mode pins |
| adc_data_i | input | DATA_W | Converter parallel data |
| adc_int_n | input | 1 | Converter done interrupt, active low |

## Verification
Two events can land in the same cycle. One is the timeout watchdog reaching its last cycle. The other is the synchronised interrupt turning low. The interrupt must win. The bench model lets the interrupt fall after a programmable number of cycles from the convert strobe's rise. It runs one command with the latest delay that should still succeed and one with a delay one cycle longer. The first must deliver all results with no error pulse. The second must raise `err_timeout` and issue no read.

// File: rtl/ash_pkg.sv
package ash_pkg;
   localparam int MODE_W = 4;
   localparam int CNT_W  = 2;

   typedef enum logic [3:0] {
      S_IDLE, S_WSU, S_WLO, S_WHO, S_CLO, S_CWAIT, S_RSU, S_RLO, S_RHO
   } ash_state_t;
endpackage

// File: rtl/ash_mode_enc.sv
module ash_mode_enc
   import ash_pkg::*;
#(
   parameter int CW = CNT_W
) (
   input  logic          bank,
   input  logic [CW-1:0] cnt_m1,
   input  logic          pdown,
   output logic [MODE_W-1:0] mode
);
   if (CW != 2) begin : g_bad_cw
      $error("ash_mode_enc: count field must be 2 bits");
   end

   // Pin order matters to the converter: count in [1:0], bank at 2, power-down at 3
   always_comb begin
      if (pdown) mode = 4'b1000;
      else       mode = {1'b0, bank, cnt_m1};
   end
endmodule

// File: rtl/ash_sync.sv
module ash_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 0) begin : g_bad_stages
      $error("ash_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_direct
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk) begin
         if (!rst_n) sr <= '1;
         else        sr <= {sr[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], d};
      end
      assign q = sr[STAGES-1];
   end
endmodule

// File: rtl/ash_dwell.sv
module ash_dwell #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] len,
   output logic         last
);
   if (W < 1) begin : g_bad_w
      $error("ash_dwell: W must be at least 1");
   end

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= len - W'(1);
      else if (cnt != '0)  cnt <= cnt - W'(1);
   end

   assign last = (cnt == '0);
endmodule

// File: rtl/adc_seq_host.sv
module adc_seq_host
   import ash_pkg::*;
#(
   parameter int DATA_W      = 12,
   parameter int TW          = 8,
   parameter int T_SU        = 2,
   parameter int T_WR        = 2,
   parameter int T_HOLD      = 1,
   parameter int T_CNV       = 2,
   parameter int T_RD        = 3,
   parameter int TIMEOUT     = 400,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_bank,
   input  logic [CNT_W-1:0]  cmd_cnt_m1,
   input  logic              cmd_pdown,
   output logic              res_valid,
   output logic [DATA_W-1:0] res_data,
   output logic [CNT_W-1:0]  res_chan,
   output logic              err_timeout,
   output logic              adc_cs_n,
   output logic              adc_wr_n,
   output logic              adc_rd_n,
   output logic              adc_cnv_n,
   output logic [MODE_W-1:0] adc_mode_o,
   output logic              adc_mode_oe,
   input  logic [DATA_W-1:0] adc_data_i,
   input  logic              adc_int_n
);
   localparam int TO_W  = $clog2(TIMEOUT + 1);
   localparam int T_LIM = 2 ** TW;

   if (T_SU < 1 || T_WR < 1 || T_HOLD < 1 || T_CNV < 1 || T_RD < 1) begin : g_bad_min
      $error("adc_seq_host: every bus timing must be at least one cycle");
   end
   if (T_SU >= T_LIM || T_WR >= T_LIM || T_HOLD >= T_LIM || T_CNV >= T_LIM || T_RD >= T_LIM) begin : g_bad_max
      $error("adc_seq_host: a bus timing does not fit TW bits");
   end
   if (TIMEOUT < 1 || DATA_W < 1) begin : g_bad_misc
      $error("adc_seq_host: TIMEOUT and DATA_W must be positive");
   end

   ash_state_t         st, st_nx;
   logic [MODE_W-1:0]  enc_mode, cur_mode, cache_mode;
   logic               cache_ok, cur_pd;
   logic [CNT_W-1:0]   cur_cnt, chan;
   logic               int_s, bus_last, to_last;
   logic               bus_ld, to_ld;
   logic [TW-1:0]      bus_len;

   ash_mode_enc #(.CW(CNT_W)) u_enc (
      .bank(cmd_bank), .cnt_m1(cmd_cnt_m1), .pdown(cmd_pdown), .mode(enc_mode));

   ash_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(adc_int_n), .q(int_s));

   ash_dwell #(.W(TW)) u_bus_tmr (
      .clk(clk), .rst_n(rst_n), .load(bus_ld), .len(bus_len), .last(bus_last));

   ash_dwell #(.W(TO_W)) u_to_tmr (
      .clk(clk), .rst_n(rst_n), .load(to_ld), .len(TO_W'(TIMEOUT)), .last(to_last));

   always_comb begin
      st_nx   = st;
      bus_ld  = 1'b0;
      bus_len = TW'(T_SU);
      to_ld   = 1'b0;
      unique case (st)
         S_IDLE: if (cmd_valid) begin
            if (!cache_ok || enc_mode != cache_mode) begin
               st_nx = S_WSU; bus_ld = 1'b1; bus_len = TW'(T_SU);
            end else if (!cmd_pdown) begin
               st_nx = S_CLO; bus_ld = 1'b1; bus_len = TW'(T_CNV);
            end
         end
         S_WSU: if (bus_last) begin st_nx = S_WLO; bus_ld = 1'b1; bus_len = TW'(T_WR); end
         S_WLO: if (bus_last) begin st_nx = S_WHO; bus_ld = 1'b1; bus_len = TW'(T_HOLD); end
         S_WHO: if (bus_last) begin
            if (cur_pd) st_nx = S_IDLE;
            else begin st_nx = S_CLO; bus_ld = 1'b1; bus_len = TW'(T_CNV); end
         end
         S_CLO: if (bus_last) begin st_nx = S_CWAIT; to_ld = 1'b1; end
         S_CWAIT: begin
            // the interrupt is tested first so it wins over a watchdog expiring in the same cycle
            if (!int_s) begin st_nx = S_RSU; bus_ld = 1'b1; bus_len = TW'(T_SU); end
            else if (to_last) st_nx = S_IDLE;
         end
         S_RSU: if (bus_last) begin st_nx = S_RLO; bus_ld = 1'b1; bus_len = TW'(T_RD); end
         S_RLO: if (bus_last) begin st_nx = S_RHO; bus_ld = 1'b1; bus_len = TW'(T_HOLD); end
         S_RHO: if (bus_last) begin
            if (chan == cur_cnt) st_nx = S_IDLE;
            else begin st_nx = S_RLO; bus_ld = 1'b1; bus_len = TW'(T_RD); end
         end
         default: st_nx = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st          <= S_IDLE;
         cur_mode    <= '0;
         cur_cnt     <= '0;
         cur_pd      <= 1'b0;
         cache_mode  <= '0;
         cache_ok    <= 1'b0;
         chan        <= '0;
         res_valid   <= 1'b0;
         res_data    <= '0;
         res_chan    <= '0;
         err_timeout <= 1'b0;
      end else begin
         st          <= st_nx;
         res_valid   <= 1'b0;
         err_timeout <= 1'b0;
         if (st == S_IDLE && cmd_valid) begin
            cur_mode <= enc_mode;
            cur_cnt  <= cmd_cnt_m1;
            cur_pd   <= cmd_pdown;
            chan     <= '0;
         end
         if (st == S_WLO && bus_last) begin
            cache_mode <= cur_mode;
            cache_ok   <= 1'b1;
         end
         if (st == S_CWAIT && int_s && to_last) err_timeout <= 1'b1;
         if (st == S_RLO && bus_last) begin
            res_valid <= 1'b1;
            res_data  <= adc_data_i;
            res_chan  <= chan;
         end
         if (st == S_RHO && bus_last && chan != cur_cnt) chan <= chan + CNT_W'(1);
      end
   end

   assign cmd_ready   = (st == S_IDLE);
   assign adc_mode_oe = (st == S_WSU) || (st == S_WLO) || (st == S_WHO);
   assign adc_cs_n    = !(adc_mode_oe || st == S_RSU || st == S_RLO || st == S_RHO);
   assign adc_wr_n    = (st != S_WLO);
   assign adc_rd_n    = (st != S_RLO);
   assign adc_cnv_n   = (st != S_CLO);
   assign adc_mode_o  = cur_mode;

   // conversion-in-flight tracker used only by the checks below
   logic conv_busy;
   always_ff @(posedge clk) begin
      if (!rst_n)                      conv_busy <= 1'b0;
      else if (!adc_cnv_n)             conv_busy <= 1'b1;
      else if (!int_s || err_timeout)  conv_busy <= 1'b0;
   end

   assert_wr_in_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !adc_wr_n |-> (!adc_cs_n && adc_mode_oe));
   assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_mode_oe && $past(adc_mode_oe)) |-> $stable(adc_mode_o));
   assert_no_overlap_cnv_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_cnv_n) |-> !conv_busy);
   assert_no_read_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      conv_busy |-> adc_rd_n);
   assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);
   assert_err_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_timeout |-> (adc_cs_n && adc_rd_n && !res_valid));
   assert_busy_no_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !cmd_ready);
endmodule

// File: tb/tb_adc_seq_host.sv
`timescale 1ns/1ps
module tb_adc_seq_host;
   localparam int DW = 12, SU = 2, WR = 2, HO = 1, CV = 2, RD = 3, TO = 40, SY = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   always #5 clk = ~clk;

   logic cmd_valid = 1'b0, cmd_bank = 1'b0, cmd_pdown = 1'b0;
   logic [1:0] cmd_cnt_m1 = '0;
   logic cmd_ready, res_valid, err_timeout;
   logic [DW-1:0] res_data;
   logic [1:0] res_chan;
   logic adc_cs_n, adc_wr_n, adc_rd_n, adc_cnv_n, adc_mode_oe;
   logic [3:0] adc_mode_o;
   logic [DW-1:0] mdl_data = '0;
   logic mdl_int_n = 1'b1;

   adc_seq_host #(.DATA_W(DW), .TW(8), .T_SU(SU), .T_WR(WR), .T_HOLD(HO), .T_CNV(CV),
                  .T_RD(RD), .TIMEOUT(TO), .SYNC_STAGES(SY)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_bank(cmd_bank), .cmd_cnt_m1(cmd_cnt_m1), .cmd_pdown(cmd_pdown),
      .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan),
      .err_timeout(err_timeout), .adc_cs_n(adc_cs_n), .adc_wr_n(adc_wr_n),
      .adc_rd_n(adc_rd_n), .adc_cnv_n(adc_cnv_n), .adc_mode_o(adc_mode_o),
      .adc_mode_oe(adc_mode_oe), .adc_data_i(mdl_data), .adc_int_n(mdl_int_n));

   int n_vec = 0, n_fail = 0;

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int cid, input int ch);
      return DW'(cid * 291 + ch * 273 + 1445);
   endfunction

   // converter model and bus monitor
   int prog_cnt = 0, cnv_cnt = 0, rd_cnt = 0, err_cnt = 0, conv_id = 0, ptr = 0;
   int cs_run = 0, wr_run = 0, rd_run = 0, cnv_run = 0, hold_run = 0;
   int int_delay = 0, int_cnt = 0, n_got = 0;
   logic [3:0] prog_mode = '0;
   logic arm = 1'b0, busy = 1'b0, int_release = 1'b0;
   logic p_cs = 1'b1, p_wr = 1'b1, p_rd = 1'b1, p_cnv = 1'b1, p_oe = 1'b0;
   logic [DW-1:0] got_data [8];
   int got_chan [8];

   always @(negedge clk) begin
      if (rst_n) begin
         if (!adc_wr_n && p_wr) chk(cs_run == SU, "R2 cs setup before write", cs_run, SU);
         if (adc_wr_n && !p_wr) begin
            chk(wr_run == WR, "R2 write width", wr_run, WR);
            chk(!adc_cs_n && adc_mode_oe, "R2 cs/oe at write rise", {adc_cs_n, adc_mode_oe}, 1);
            prog_cnt++;
            prog_mode = adc_mode_o;
            hold_run = 0;
         end
         if (adc_cs_n && !p_cs && p_oe) chk(hold_run == HO, "R2 hold after write", hold_run, HO);
         if (adc_cnv_n && !p_cnv) begin
            chk(cnv_run == CV, "R4 convert width", cnv_run, CV);
            cnv_cnt++; conv_id++; ptr = 0; busy = 1'b1;
            if (int_delay >= 0) begin arm = 1'b1; int_cnt = int_delay; end
         end
         if (!adc_rd_n && p_rd) begin
            chk(!busy, "R5 read during conversion", busy, 0);
            chk(!adc_cs_n, "R6 cs during read", adc_cs_n, 0);
            mdl_int_n = 1'b1;
         end
         if (adc_rd_n && !p_rd) begin
            chk(rd_run == RD, "R6 read width", rd_run, RD);
            rd_cnt++; ptr++;
         end
         if (res_valid) begin
            chk(!p_rd && adc_rd_n, "R7 valid timing", {p_rd, adc_rd_n}, 1);
            chk(!cmd_ready, "R9 ready low with result", cmd_ready, 0);
            if (n_got < 8) begin got_data[n_got] = res_data; got_chan[n_got] = res_chan; end
            n_got++;
         end
         if (err_timeout) err_cnt++;
         if (arm) begin
            if (int_cnt == 0) begin mdl_int_n = 1'b0; arm = 1'b0; busy = 1'b0; end
            else int_cnt--;
         end
         if (int_release) begin mdl_int_n = 1'b1; int_release = 1'b0; end
         // correct data only in the last low cycle of the read strobe
         mdl_data = (!adc_rd_n && rd_run == RD - 1) ? pat(conv_id, ptr) : ~pat(conv_id, ptr);
         if (!adc_wr_n && p_wr) hold_run = 0;
         else if (!adc_cs_n && adc_wr_n && adc_mode_oe) hold_run++;
         cs_run  = adc_cs_n  ? 0 : cs_run + 1;
         wr_run  = adc_wr_n  ? 0 : wr_run + 1;
         rd_run  = adc_rd_n  ? 0 : rd_run + 1;
         cnv_run = adc_cnv_n ? 0 : cnv_run + 1;
      end
      p_cs = adc_cs_n; p_wr = adc_wr_n; p_rd = adc_rd_n; p_cnv = adc_cnv_n; p_oe = adc_mode_oe;
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   task automatic send(input logic bank, input int n, input logic pd);
      @(negedge clk);
      chk(cmd_ready, "R9 ready before command", cmd_ready, 1);
      cmd_valid = 1'b1; cmd_bank = bank; cmd_cnt_m1 = 2'(n - 1); cmd_pdown = pd;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_pdown = 1'b0;
   endtask

   task automatic wait_ready();
      int k = 0;
      while (!cmd_ready && k < 2000) begin @(negedge clk); k++; end
      chk(k < 2000, "R9 ready returns", k, 0);
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset_state();
      chk(adc_cs_n && adc_wr_n && adc_rd_n && adc_cnv_n, "R11 strobes high",
          {adc_cs_n, adc_wr_n, adc_rd_n, adc_cnv_n}, 4'hF);
      chk(!adc_mode_oe && !res_valid && !err_timeout, "R11 flags low",
          {adc_mode_oe, res_valid, err_timeout}, 0);
      chk(cmd_ready, "R11 ready high", cmd_ready, 1);
   endtask

   task automatic t_run(input logic bank, input int n, input int exp_prog);
      int p0 = prog_cnt, c0 = cnv_cnt, r0 = rd_cnt, e0 = err_cnt;
      logic [3:0] exp_mode = {1'b0, bank, 2'(n - 1)};
      n_got = 0;
      send(bank, n, 1'b0);
      chk(!cmd_ready, "R9 ready low after accept", cmd_ready, 0);
      wait_ready();
      chk(prog_cnt - p0 == exp_prog, "R3 write cycles", prog_cnt - p0, exp_prog);
      chk(prog_mode == exp_mode, "R1 mode word", prog_mode, exp_mode);
      chk(cnv_cnt - c0 == 1, "R4 one convert pulse", cnv_cnt - c0, 1);
      chk(rd_cnt - r0 == n, "R6 read count", rd_cnt - r0, n);
      chk(n_got == n, "R6 result count", n_got, n);
      chk(err_cnt == e0, "R8 no error", err_cnt - e0, 0);
      for (int i = 0; i < n && i < 8; i++) begin
         chk(got_chan[i] == i, "R6 channel order", got_chan[i], i);
         chk(got_data[i] == pat(conv_id, i), "R7 sampled data", got_data[i], pat(conv_id, i));
      end
   endtask

   task automatic t_timeout(input int d);
      int r0 = rd_cnt, e0 = err_cnt;
      n_got = 0;
      int_delay = d;
      send(1'b0, 2, 1'b0);
      wait_ready();
      chk(err_cnt - e0 == 1, "R8 error pulse", err_cnt - e0, 1);
      chk(rd_cnt == r0 && n_got == 0, "R8 no read after timeout", rd_cnt - r0, 0);
      @(posedge clk); #1 int_release = 1'b1;
      repeat (SY + 4) @(negedge clk);
      int_delay = 0;
   endtask

   task automatic t_boundary();
      // last delay still accepted: driven low at negedge D gives a synced low in cycle D+SY
      int_delay = TO - SY - 1;
      t_run(1'b0, 2, 0);
      int_delay = 0;
      t_timeout(TO - SY);
   endtask

   task automatic t_pdown();
      int p0 = prog_cnt, c0 = cnv_cnt;
      send(1'b0, 1, 1'b1);
      wait_ready();
      chk(prog_cnt - p0 == 1, "R10 power-down written", prog_cnt - p0, 1);
      chk(prog_mode == 4'b1000, "R10 power-down word R1", prog_mode, 4'b1000);
      chk(cnv_cnt == c0, "R10 no convert", cnv_cnt - c0, 0);
      send(1'b1, 3, 1'b1);
      wait_ready();
      chk(prog_cnt - p0 == 1, "R3 repeat power-down skipped", prog_cnt - p0, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset_state();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_run(1'b0, 1, 1);
      t_run(1'b0, 1, 0);
      t_run(1'b1, 4, 1);
      t_run(1'b1, 3, 1);
      t_run(1'b1, 3, 0);
      t_run(1'b0, 2, 1);
      int_delay = 5;
      t_run(1'b1, 2, 1);
      int_delay = 0;
      t_timeout(-1);
      t_boundary();
      t_pdown();
      t_run(1'b0, 4, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end
endmodule